// File: doc/BRIEF.md
# Input Synchronizer With Hold

This block brings a multi-bit bus that changes with no relation to the fabric clock into that clock's domain. It passes the bus through a chain of flip-flops whose length is fixed when the block is elaborated. When the consumer of the data does not run on every clock cycle, the block also adds a holding register. That register captures the synchronized value only on a read strobe and keeps it steady between reads.

Two parameters set the configuration. `DEPTH_SEL` takes 0, 1, 2, or the Auto value -1. `EVERY_CYCLE` says whether the consumer runs on every clock. Auto picks two stages for an every-cycle consumer. For an occasional consumer, Auto picks one stage followed by the holding register. Depth 0 with an every-cycle consumer is a plain wire from input to output. It is only meant for a signal that is already synchronized upstream. Any other `DEPTH_SEL` value stops elaboration.

Top module: `input_sync_hold`

## Requirements
- R1: Every-cycle consumer, depth 1 or 2: after each clock edge, `data_out` shows the input sampled that many edges back. The latest edge counts as one back.
- R2: Every-cycle consumer, Auto depth: two synchronizing stages and no holding register. The output follows the input with two edges of latency, and `rd_stb` has no effect on it.
- R3: Occasional consumer, Auto depth: one stage, then the holding register. On an edge with `rd_stb` high, the holding register takes the input value that was sampled one edge earlier.
- R4: Occasional consumer, depth N of 0, 1 or 2: on an edge with `rd_stb` high, the holding register takes the input value from N edges earlier. With N = 0 this is the value present at that same edge.
- R5: Every-cycle consumer, depth 0: `data_out` equals `async_in` within the same cycle, with no clock edge in between.
- R6: Occasional consumer: an edge with `rd_stb` low and reset low leaves `data_out` unchanged.
- R7: Occasional consumer: `valid_out` is high for exactly the one cycle after each edge that had `rd_stb` high and reset low. At all other times it is low.
- R8: Every-cycle consumer: `valid_out` goes high at the first edge with reset low and stays high until the next reset. `rd_stb` has no effect on it.
- R9: Reset is synchronous and active high. After an edge with `rst` high, every stage, the holding register and `valid_out` read zero. The only exception is the data path of a depth-0 every-cycle configuration, which is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| async_in | input | WIDTH | Input bus, not related to `clk` |
| rd_stb | input | 1 | Read strobe for the holding register; not used by every-cycle configurations |
| data_out | output | WIDTH | Synchronized data, or the held value when there is a holding register |
| valid_out | output | 1 | Capture pulse for occasional consumers; level high out of reset for every-cycle consumers |

## Verification
A stage that is missing or extra moves `data_out` by one edge against the input history. This shows on the first edge after the input changes. A holding register that loads without a strobe changes `data_out` at the next edge on which the synchronizer output differs from the held value. One that takes its value from the wrong tap shows a wrong value in the cycle right after the strobe. A wrong valid register shows within one cycle of a strobe, or at the first edge after reset.

// File: rtl/isync_pkg.sv
package isync_pkg;

    localparam int ISYNC_DEPTH_AUTO = -1;

    function automatic bit depth_legal(input int sel);
        return (sel == ISYNC_DEPTH_AUTO) || (sel >= 0 && sel <= 2);
    endfunction

    // Auto gives two stages for an every-cycle consumer; an occasional
    // consumer gets one stage because the holding register follows it.
    function automatic int resolve_depth(input int sel, input bit every_cycle);
        if (!depth_legal(sel))
            return 0;
        if (sel == ISYNC_DEPTH_AUTO)
            return every_cycle ? 2 : 1;
        return sel;
    endfunction

endpackage

// File: rtl/isync_stage_chain.sv
module isync_stage_chain #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } chain_t;

    chain_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        ch_d.stg[0] = d_in;
        for (int k = 1; k < STAGES; k++) begin
            ch_d.stg[k] = ch_q.stg[k-1];
        end
        if (rst) begin
            ch_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ch_q <= ch_d;
    end

    assign d_out = ch_q.stg[STAGES-1];

endmodule

// File: rtl/isync_hold_reg.sv
module isync_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out,
    output logic             cap_pulse
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             pulse;
    } hold_t;

    hold_t hr_d, hr_q;

    always_comb begin
        hr_d       = hr_q;
        hr_d.pulse = cap_en;
        if (cap_en) begin
            hr_d.data = d_in;
        end
        if (rst) begin
            hr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        hr_q <= hr_d;
    end

    assign q_out     = hr_q.data;
    assign cap_pulse = hr_q.pulse;

endmodule

// File: rtl/input_sync_hold.sv
module input_sync_hold
    import isync_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int DEPTH_SEL   = ISYNC_DEPTH_AUTO,
    parameter bit EVERY_CYCLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    input  logic             rd_stb,
    output logic [WIDTH-1:0] data_out,
    output logic             valid_out
);

    localparam int SYNC_STAGES = resolve_depth(DEPTH_SEL, EVERY_CYCLE);
    localparam bit USE_HOLD    = !EVERY_CYCLE;

    logic [WIDTH-1:0] sync_tap;

    generate
        if (!depth_legal(DEPTH_SEL)) begin : g_bad_depth
            $error("input_sync_hold: DEPTH_SEL must be -1 (auto), 0, 1 or 2");
        end
    endgenerate

    generate
        if (SYNC_STAGES == 0) begin : g_no_stages
            assign sync_tap = async_in;
        end else begin : g_stages
            isync_stage_chain #(
                .WIDTH (WIDTH),
                .STAGES(SYNC_STAGES)
            ) u_chain (
                .clk  (clk),
                .rst  (rst),
                .d_in (async_in),
                .d_out(sync_tap)
            );
        end
    endgenerate

    generate
        if (USE_HOLD) begin : g_hold
            isync_hold_reg #(
                .WIDTH(WIDTH)
            ) u_hold (
                .clk      (clk),
                .rst      (rst),
                .cap_en   (rd_stb),
                .d_in     (sync_tap),
                .q_out    (data_out),
                .cap_pulse(valid_out)
            );
        end else begin : g_live
            typedef struct packed {
                logic valid;
            } live_t;

            live_t lv_d, lv_q;
            logic  stb_unused;

            assign stb_unused = rd_stb;

            always_comb begin
                lv_d       = lv_q;
                lv_d.valid = 1'b1;
                if (rst) begin
                    lv_d = '0;
                end
            end

            always_ff @(posedge clk) begin
                lv_q <= lv_d;
            end

            assign data_out  = sync_tap;
            assign valid_out = lv_q.valid;
        end
    endgenerate

endmodule

// File: rtl/isync_checker.sv
module isync_checker
    import isync_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int DEPTH_SEL   = ISYNC_DEPTH_AUTO,
    parameter bit EVERY_CYCLE = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] async_in,
    input logic             rd_stb,
    input logic [WIDTH-1:0] sync_tap,
    input logic [WIDTH-1:0] data_out,
    input logic             valid_out
);

    localparam int NSTG = resolve_depth(DEPTH_SEL, EVERY_CYCLE);

    logic [1:0] since_rst;
    logic       chk_unused;

    assign chk_unused = ^{rd_stb, sync_tap, async_in};

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    generate
        if (!EVERY_CYCLE) begin : g_occ
            AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) !rd_stb |=> $stable(data_out)) else $error("hold changed without strobe"); // R6
            AST_CAPTURE_TAP: assert property (@(posedge clk) disable iff (rst) rd_stb |=> data_out == $past(sync_tap)) else $error("hold missed capture"); // R4
            AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) rd_stb |=> valid_out) else $error("valid missing after strobe"); // R7
            AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst) !rd_stb |=> !valid_out) else $error("valid without strobe"); // R7
        end else begin : g_every
            AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> valid_out) else $error("valid dropped"); // R8
            if (NSTG == 1) begin : g_lat1
                AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (rst) (since_rst >= 2'd1) |-> data_out == $past(async_in, 1)) else $error("latency one wrong"); // R1
            end
            if (NSTG == 2) begin : g_lat2
                AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst) (since_rst >= 2'd2) |-> data_out == $past(async_in, 2)) else $error("latency two wrong"); // R2
            end
            if (NSTG == 0) begin : g_comb
                always_comb begin
                    AST_COMB_PATH: assert (data_out == async_in) else $error("combinational path differs"); // R5
                end
            end
        end
        if (!(EVERY_CYCLE && NSTG == 0)) begin : g_rst_data
            AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (data_out == '0)) else $error("data not cleared"); // R9
        end
    endgenerate

    AST_RESET_VALID: assert property (@(posedge clk) rst |=> !valid_out) else $error("valid not cleared"); // R9

endmodule

bind input_sync_hold isync_checker #(
    .WIDTH      (WIDTH),
    .DEPTH_SEL  (DEPTH_SEL),
    .EVERY_CYCLE(EVERY_CYCLE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .async_in (async_in),
    .rd_stb   (rd_stb),
    .sync_tap (sync_tap),
    .data_out (data_out),
    .valid_out(valid_out)
);

// File: tb/sim_input_sync_hold.sv
module sim_input_sync_hold;

    localparam int W = 8;
    localparam int NI = 8;
    // configurations: 0 auto/every, 1 d0/every, 2 d1/every, 3 d2/every,
    // 4 auto/occ, 5 d0/occ, 6 d1/occ, 7 d2/occ
    localparam int EFF_DEP [NI] = '{2, 0, 1, 2, 1, 0, 1, 2};
    localparam bit IS_EVERY[NI] = '{1, 1, 1, 1, 0, 0, 0, 0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         stb = 1'b0;
    logic [W-1:0] dout [NI];
    logic         vout [NI];

    logic [W-1:0] h [4];
    logic [W-1:0] hold_m [NI];
    logic [15:0]  lfsr = 16'hACE1;
    int           n_chk = 0;
    int           n_fail = 0;

    always #4 clk = ~clk;

    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(-1), .EVERY_CYCLE(1'b1)) u0 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[0]), .valid_out(vout[0]));
    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(0),  .EVERY_CYCLE(1'b1)) u1 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[1]), .valid_out(vout[1]));
    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(1),  .EVERY_CYCLE(1'b1)) u2 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[2]), .valid_out(vout[2]));
    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(2),  .EVERY_CYCLE(1'b1)) u3 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[3]), .valid_out(vout[3]));
    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(-1), .EVERY_CYCLE(1'b0)) u4 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[4]), .valid_out(vout[4]));
    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(0),  .EVERY_CYCLE(1'b0)) u5 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[5]), .valid_out(vout[5]));
    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(1),  .EVERY_CYCLE(1'b0)) u6 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[6]), .valid_out(vout[6]));
    input_sync_hold #(.WIDTH(W), .DEPTH_SEL(2),  .EVERY_CYCLE(1'b0)) u7 (.clk(clk), .rst(rst), .async_in(din), .rd_stb(stb), .data_out(dout[7]), .valid_out(vout[7]));

    function automatic string data_tag(input int i, input logic s, input logic r);
        if (r && !(i == 1)) return "R9";
        if (i == 1) return "R5";
        if (i == 0) return "R2";
        if (IS_EVERY[i]) return "R1";
        if (!s) return "R6";
        if (i == 4) return "R3";
        return "R4";
    endfunction

    function automatic string valid_tag(input int i, input logic r);
        if (r) return "R9";
        return IS_EVERY[i] ? "R8" : "R7";
    endfunction

    task automatic check(input string tag, input int i, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s u%0d %s: actual %0h expected %0h at %0t", tag, i, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, update the model at the edge, compare 2 ns later
    task automatic step(input logic [W-1:0] val, input logic s, input logic r);
        logic [W-1:0] exp_d;
        logic         exp_v;
        @(negedge clk);
        din = val;
        stb = s;
        rst = r;
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < 4; k++) h[k] = '0;
        end else begin
            h[3] = h[2];
            h[2] = h[1];
            h[1] = h[0];
            h[0] = val;
        end
        for (int i = 0; i < NI; i++) begin
            if (!IS_EVERY[i]) begin
                if (r) hold_m[i] = '0;
                else if (s) hold_m[i] = h[EFF_DEP[i]];
            end
        end
        #2;
        for (int i = 0; i < NI; i++) begin
            if (IS_EVERY[i]) begin
                exp_d = (EFF_DEP[i] == 0) ? val : h[EFF_DEP[i] - 1];
                exp_v = !r;
            end else begin
                exp_d = hold_m[i];
                exp_v = s && !r;
            end
            check(data_tag(i, s, r), i, "data", dout[i], exp_d);
            check(valid_tag(i, r), i, "valid", {7'd0, vout[i]}, {7'd0, exp_v});
        end
    endtask

    task automatic next_rand(output logic [W-1:0] v);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v = lfsr[W-1:0];
    endtask

    // R9: outputs and valid clear while reset is held, even with input and strobe active
    task automatic t_reset_state();
        for (int k = 0; k < 4; k++) step(8'hA5 ^ 8'(k), 1'b1, 1'b1);
    endtask

    // R1 R2 R5 R8 R6: walking-one stream, no strobe, so every held output stays zero
    task automatic t_walking();
        for (int k = 0; k < 2 * W; k++) step(8'h01 << (k % W), 1'b0, 1'b0);
        step(8'h00, 1'b0, 1'b0);
        step(8'hFF, 1'b0, 1'b0);
        step(8'hFF, 1'b0, 1'b0);
    endtask

    // R3 R4 R6 R7: changing data, strobe on every third edge
    task automatic t_sparse_strobe();
        logic [W-1:0] v;
        for (int k = 0; k < 30; k++) begin
            next_rand(v);
            step(v, (k % 3) == 2, 1'b0);
        end
    endtask

    // R3 R4 R7: strobe held high for a run, hold follows its tap each edge
    task automatic t_strobe_burst();
        logic [W-1:0] v;
        for (int k = 0; k < 12; k++) begin
            next_rand(v);
            step(v, 1'b1, 1'b0);
        end
        for (int k = 0; k < 5; k++) step(8'h3C, 1'b0, 1'b0);
    endtask

    // R9 R8: reset pulse in the middle of traffic, then recovery
    task automatic t_mid_reset();
        logic [W-1:0] v;
        for (int k = 0; k < 4; k++) begin
            next_rand(v);
            step(v, 1'b1, 1'b0);
        end
        step(8'h77, 1'b1, 1'b1);
        step(8'h88, 1'b0, 1'b1);
        for (int k = 0; k < 10; k++) begin
            next_rand(v);
            step(v, (k % 2) == 1, 1'b0);
        end
    endtask

    initial begin
        for (int k = 0; k < 4; k++) h[k] = '0;
        for (int i = 0; i < NI; i++) hold_m[i] = '0;
        t_reset_state();
        t_walking();
        t_sparse_strobe();
        t_strobe_burst();
        t_mid_reset();
        t_sparse_strobe();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule